// File: doc/BRIEF.md
# Programmable Routing Switch Box

This block is the crossing point where routing tracks from the four compass sides meet between logic islands. Each side has `W` tracks. Every side has an inbound and an outbound bundle, so the interconnect is modelled as plain directional logic. Each outbound track can be fed from the same-numbered track on any of the other three sides. A signal can therefore run straight across, turn a corner, or branch to two or three sides at once.

Connectivity lives in a small bank of link-enable cells, three per outbound track. A link is active only while its cell holds 1. Software writes the cells at configuration time through an addressed write port, and they do not change while the fabric runs. When more than one link drives the same outbound track, the sources are merged by OR and a conflict flag is raised.

Reset is asserted asynchronously and released on a clock edge. After reset every link is off and every output is low.

Top module: `sbox_switch`

## Requirements
- R1: While reset is active and after it is released, all link cells are 0, every outbound track is 0 whatever the inputs are, and `cfg_conflict` is 0.
- R2: A write with `cfg_we`=1 selects one outbound track. `cfg_addr[1:0]` gives the side (0 north, 1 east, 2 south, 3 west) and the upper address bits give the track number. The three `cfg_data` bits replace that track's link cells at the clock edge where the write is sampled, and the new setting drives the outputs from then on.
- R3: For outbound side s, data bit 1 enables the opposite side (s+2 mod 4), which gives a straight-through path.
- R4: Data bit 0 enables side s+1 mod 4 and data bit 2 enables side s+3 mod 4, which give the two turning paths.
- R5: One inbound track can drive outbound tracks on several sides at the same time when each of those sides has its link to it enabled.
- R6: Track i connects only to track i on the other sides. An inbound track never reaches an outbound track with a different number.
- R7: An outbound track with more than one enabled link carries the OR of those sources. `cfg_conflict` is 1 exactly when at least one outbound track has two or more links enabled.
- R8: While `cfg_we` is 0, the link cells keep their values no matter what `cfg_addr` and `cfg_data` do.
- R9: Writing 0 to a track's cells disconnects it, and its output then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2+clog2(W) | Side in bits [1:0], track in the bits above them |
| cfg_data | input | 3 | Link enables: bit0 side+1, bit1 opposite side, bit2 side+3 |
| in_n | input | W | Inbound tracks from the north |
| in_e | input | W | Inbound tracks from the east |
| in_s | input | W | Inbound tracks from the south |
| in_w | input | W | Inbound tracks from the west |
| out_n | output | W | Outbound tracks to the north |
| out_e | output | W | Outbound tracks to the east |
| out_s | output | W | Outbound tracks to the south |
| out_w | output | W | Outbound tracks to the west |
| cfg_conflict | output | 1 | High when any outbound track has two or more links enabled |

## Verification
There is exactly one register stage in the block: a write changes the link cells at the rising edge that samples it. From then on, the outputs and the conflict flag are pure logic of the cells and the inbound tracks, so they follow input changes within the same cycle. The bench therefore applies writes and input patterns on the falling edge. It samples one nanosecond later, before the next rising edge. An independent table of link cells in the bench gives the expected value of every outbound bit and of the conflict flag. The hold test changes the address and data lines with the write enable low and then compares all outputs against that unchanged table.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  localparam int NUM_SIDES = 4;
  localparam int NUM_SRC   = 3;

  typedef enum logic [1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;

  // Source side feeding link-enable bit k of an outbound track on side s.
  function automatic int src_side(input int s, input int k);
    return (s + k + 1) % NUM_SIDES;
  endfunction

endpackage

// File: rtl/sbox_rst_sync.sv
module sbox_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sbox_cfg_store.sv
module sbox_cfg_store
  import sbox_pkg::*;
#(
  parameter int W      = 4,
  parameter int ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NUM_SRC-1:0]             wdata,
  output logic [NUM_SIDES*W-1:0][NUM_SRC-1:0] cfg_q,
  output logic                           conflict
);

  localparam int NUM_ENT = NUM_SIDES * W;

  logic                               addr_ok;
  logic                               cfg_en;
  logic [NUM_ENT-1:0][NUM_SRC-1:0]    cfg_d;

  assign addr_ok = ({1'b0, addr} < (ADDR_W+1)'(NUM_ENT));
  assign cfg_en  = we & addr_ok;

  always_comb begin
    cfg_d = cfg_q;
    for (int e = 0; e < NUM_ENT; e++) begin
      if (addr == ADDR_W'(e)) begin
        cfg_d[e] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  // Any outbound track with two or more enabled links.
  always_comb begin
    conflict = 1'b0;
    for (int e = 0; e < NUM_ENT; e++) begin
      conflict = conflict |
                 (cfg_q[e][0] & cfg_q[e][1]) |
                 (cfg_q[e][0] & cfg_q[e][2]) |
                 (cfg_q[e][1] & cfg_q[e][2]);
    end
  end

  // R8: cells stay put without a write strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q));

  // R1: reset holds every cell at zero
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (cfg_q == '0));

endmodule

// File: rtl/sbox_link_mux.sv
module sbox_link_mux
  import sbox_pkg::*;
(
  input  logic [NUM_SRC-1:0] sel,
  input  logic [NUM_SRC-1:0] src,
  output logic               y
);

  assign y = |(sel & src);

endmodule

// File: rtl/sbox_switch.sv
module sbox_switch
  import sbox_pkg::*;
#(
  parameter int W      = 4,
  parameter int TRK_W  = (W > 1) ? $clog2(W) : 1,
  parameter int ADDR_W = 2 + TRK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [2:0]        cfg_data,
  input  logic [W-1:0]      in_n,
  input  logic [W-1:0]      in_e,
  input  logic [W-1:0]      in_s,
  input  logic [W-1:0]      in_w,
  output logic [W-1:0]      out_n,
  output logic [W-1:0]      out_e,
  output logic [W-1:0]      out_s,
  output logic [W-1:0]      out_w,
  output logic              cfg_conflict
);

  localparam int NUM_ENT = NUM_SIDES * W;

  logic                            rst_sync_n;
  logic [NUM_ENT-1:0][NUM_SRC-1:0] cfg_q;
  logic [NUM_SIDES-1:0][W-1:0]     side_in;
  logic [NUM_SIDES-1:0][W-1:0]     side_out;
  logic                            link_y [NUM_ENT];

  sbox_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sbox_cfg_store #(.W(W), .ADDR_W(ADDR_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_data),
    .cfg_q    (cfg_q),
    .conflict (cfg_conflict)
  );

  assign side_in[SIDE_N] = in_n;
  assign side_in[SIDE_E] = in_e;
  assign side_in[SIDE_S] = in_s;
  assign side_in[SIDE_W] = in_w;

  // Entry index = track*4 + side, matching the write address layout.
  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    for (genvar t = 0; t < W; t++) begin : g_trk
      sbox_link_mux u_mux (
        .sel (cfg_q[t*NUM_SIDES + s]),
        .src ({side_in[src_side(s, 2)][t],
               side_in[src_side(s, 1)][t],
               side_in[src_side(s, 0)][t]}),
        .y   (link_y[t*NUM_SIDES + s])
      );
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SIDES; s++) begin
      for (int t = 0; t < W; t++) begin
        side_out[s][t] = link_y[t*NUM_SIDES + s];
      end
    end
  end

  assign out_n = side_out[SIDE_N];
  assign out_e = side_out[SIDE_E];
  assign out_s = side_out[SIDE_S];
  assign out_w = side_out[SIDE_W];

  // R2: an accepted write lands in the addressed cells at the next edge
  p_write_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && ({1'b0, cfg_addr} < (ADDR_W+1)'(NUM_ENT)))
      |=> (cfg_q[$past(cfg_addr)] == $past(cfg_data)));

  // R1: with no link enabled nothing reaches the outputs
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_q == '0) |-> ({out_w, out_s, out_e, out_n} == '0));

  // R7: fewer than two enabled links in total cannot be a conflict
  p_no_false_conflict_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($countones(cfg_q) < 2) |-> !cfg_conflict);

endmodule

// File: tb/tb_sbox_switch.sv
`timescale 1ns/1ps
module tb_sbox_switch;

  localparam int W      = 4;
  localparam int TRK_W  = 2;
  localparam int ADDR_W = 2 + TRK_W;
  localparam int NE     = 4 * W;

  logic              clk;
  logic              rst_n;
  logic              cfg_we;
  logic [ADDR_W-1:0] cfg_addr;
  logic [2:0]        cfg_data;
  logic [W-1:0]      in_n, in_e, in_s, in_w;
  logic [W-1:0]      out_n, out_e, out_s, out_w;
  logic              cfg_conflict;

  logic [2:0]        en [NE];
  logic [3:0][W-1:0] din;
  int                n_total;
  int                n_pass;

  sbox_switch #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .in_n(in_n), .in_e(in_e), .in_s(in_s), .in_w(in_w),
    .out_n(out_n), .out_e(out_e), .out_s(out_s), .out_w(out_w),
    .cfg_conflict(cfg_conflict)
  );

  assign in_n = din[0];
  assign in_e = din[1];
  assign in_s = din[2];
  assign in_w = din[3];

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [4*W-1:0] exp_out();
    logic [4*W-1:0] r;
    r = '0;
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < W; t++) begin
        for (int k = 0; k < 3; k++) begin
          if (en[t*4+s][k]) r[s*W+t] = r[s*W+t] | din[(s+k+1)%4][t];
        end
      end
    end
    return r;
  endfunction

  function automatic logic exp_conflict();
    logic c;
    c = 1'b0;
    for (int e = 0; e < NE; e++) begin
      if ($countones(en[e]) > 1) c = 1'b1;
    end
    return c;
  endfunction

  task automatic check_all(input string req);
    logic [4*W-1:0] act;
    logic [4*W-1:0] exp;
    act = {out_w, out_s, out_e, out_n};
    exp = exp_out();
    n_total++;
    if (act === exp) n_pass++;
    else $display("FAIL %s outputs actual=%h expected=%h", req, act, exp);
    n_total++;
    if (cfg_conflict === exp_conflict()) n_pass++;
    else $display("FAIL %s conflict actual=%b expected=%b", req, cfg_conflict, exp_conflict());
  endtask

  task automatic wr(input int side, input int trk, input logic [2:0] bits);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_addr = ADDR_W'(trk*4 + side);
    cfg_data = bits;
    @(posedge clk);
    en[trk*4+side] = bits;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(input logic [W-1:0] n, e, s, w);
    @(negedge clk);
    din[0] = n; din[1] = e; din[2] = s; din[3] = w;
    #1;
  endtask

  task automatic clear_all();
    for (int e = 0; e < NE; e++) wr(e % 4, e / 4, 3'b000);
  endtask

  task automatic t_reset();
    drive('1, '1, '1, '1);
    check_all("R1 reset");
  endtask

  task automatic t_address();
    // R2: east side (1), track 2 -> address 9, straight from west
    wr(1, 2, 3'b010);
    drive('0, '0, '0, 4'b0100);
    check_all("R2 addressed write");
    drive('1, '1, '1, '1);
    check_all("R2 addressed write all ones");
    clear_all();
  endtask

  task automatic t_straight();
    wr(0, 0, 3'b010);  // north trk0 from south
    wr(2, 3, 3'b010);  // south trk3 from north
    drive('0, '0, 4'b0001, '0);
    check_all("R3 straight S->N");
    drive(4'b1000, '1, '0, '1);
    check_all("R3 straight N->S");
    clear_all();
  endtask

  task automatic t_turn();
    wr(2, 1, 3'b001);  // south trk1 from west
    wr(3, 2, 3'b100);  // west trk2 from south
    drive('0, '0, '0, 4'b0010);
    check_all("R4 turn W->S");
    drive('1, '1, 4'b0100, '0);
    check_all("R4 turn S->W");
    clear_all();
  endtask

  task automatic t_fanout();
    wr(0, 1, 3'b100);  // north from west
    wr(1, 1, 3'b010);  // east from west
    wr(2, 1, 3'b001);  // south from west
    drive('0, '0, '0, 4'b0010);
    check_all("R5 fanout high");
    drive('1, '1, '1, 4'b1101);
    check_all("R5 fanout low");
  endtask

  task automatic t_isolation();
    clear_all();
    for (int t = 0; t < W; t++) wr(0, t, 3'b010);
    for (int t = 0; t < W; t++) begin
      drive('0, '1, W'(1) << t, '1);
      check_all("R6 track isolation");
    end
  endtask

  task automatic t_merge();
    wr(0, 3, 3'b111);
    drive('0, '0, '0, '0);
    check_all("R7 merge idle");
    drive('0, 4'b1000, '0, '0);
    check_all("R7 merge east");
    drive('0, '0, '0, 4'b1000);
    check_all("R7 merge west");
  endtask

  task automatic t_hold();
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      cfg_addr = ADDR_W'(i * 3);
      cfg_data = 3'(i);
      @(negedge clk);
    end
    drive('1, '1, '1, '1);
    check_all("R8 hold");
    drive(4'b0101, 4'b1010, 4'b0011, 4'b1100);
    check_all("R8 hold pattern");
  endtask

  task automatic t_clear();
    clear_all();
    drive('1, '1, '1, '1);
    check_all("R9 clear");
  endtask

  initial begin
    #100000;
    n_total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    n_total = 0;
    n_pass  = 0;
    rst_n    = 1'b0;
    cfg_we   = 1'b0;
    cfg_addr = '0;
    cfg_data = '0;
    din      = '0;
    for (int e = 0; e < NE; e++) en[e] = 3'b000;
    repeat (3) @(posedge clk);
    drive('1, '1, '1, '1);
    check_all("R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_address();
    t_straight();
    t_turn();
    t_fanout();
    t_isolation();
    t_merge();
    t_hold();
    t_clear();
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

endmodule